// File: doc/BRIEF.md
# Cached Sprite Table Scanner

This block decides, one scanline ahead, which sprites will appear on the next line. It reads an on-chip cached copy of the sprite attribute table and starts at entry 0. For each entry it takes the vertical position, the height and the index of the next entry, and walks the chain that these indices form. Every entry that covers the upcoming line is appended, in visit order, to a list of sprite indices. A counter and an overflow flag go with the list.

The walk is paced by the line's memory access schedule. It advances only on sprite access slots numbered 3 through 52, and only when the display is enabled. In each such slot it examines two chained entries through two asynchronous read ports of the cache. The second read address is the link field returned by the first read. From slot 53 onward the window is closed. Slots that fall while the display is off are lost. Because of this, entries far down the chain can miss the next line even when few sprites share it, so truncation depends on position in the chain, not on how many sprites a line holds.

The controller has four states. `ST_IDLE` is the state after reset. `ST_WALK` means the walk is in progress. `ST_END` means the chain ended, through a terminating link or the entry limit. `ST_CUT` means the window closed before the chain ended. The transitions are:
- line start takes any state to `ST_WALK`;
- a terminator takes `ST_WALK` to `ST_END`;
- a slot numbered 53 or higher takes `ST_WALK` to `ST_CUT`.

Top module: `sprite_table_scanner`

## Requirements
- R1: A `line_start` pulse latches `next_line`, clears the list, count and overflow flag, leaves `scan_done` and `scan_cut` low, and restarts the walk at entry 0. Entry 0 is always the first entry examined.
- R2: A slot strobe whose `slot_idx` is below 3 has no effect: the count, the list and the read address are unchanged.
- R3: Each scanning slot (strobe, display enabled, `slot_idx` from 3 to 52, walk in progress) examines the current entry, then the entry named by its link field. The list count therefore grows by at most 2 per slot.
- R4: A scanning-range slot that arrives while `disp_en` is low does no work and is not made up later.
- R5: A strobe with `slot_idx` of 53 or more while the walk is in progress sets `scan_done` and `scan_cut`. Both stay set, and the list stays unchanged, until the next line start.
- R6: An examined entry whose link field is 0 ends the walk after that entry. `scan_done` is then set and `scan_cut` stays low.
- R7: At most 80 entries are examined per line, even if the chain loops.
- R8: An examined entry whose link field is 80 or more ends the walk after that entry, as in R6.
- R9: Each entry is 18 bits: bits 8:0 hold the vertical position Y, bits 10:9 hold the height in 8-line cells minus one, and bits 17:11 hold the link. The entry is visible on line L when L−Y is at least 0 and less than 8×(height+1).
- R10: Visible indices fill `vis_list` in visit order, slot k in bits 7k+6:7k, with at most 20 entries. A further visible entry is dropped and sets `vis_overflow`, which implies a count of 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse that begins the scan for a new line |
| next_line | input | 9 | Number of the line being prepared, sampled at `line_start` |
| slot_strobe | input | 1 | Marks a cycle that carries a sprite access slot |
| slot_idx | input | 6 | Index of the current sprite access slot |
| disp_en | input | 1 | Display enable; scanning slots are lost while low |
| rd_addr_a | output | 7 | Cache read address, first entry of the slot |
| rd_data_a | input | 18 | Cache read data for `rd_addr_a`, same cycle |
| rd_addr_b | output | 7 | Cache read address, second entry (link of the first) |
| rd_data_b | input | 18 | Cache read data for `rd_addr_b`, same cycle |
| vis_list | output | 140 | Visible sprite indices, 20 slots of 7 bits |
| vis_count | output | 5 | Number of valid entries in `vis_list` |
| vis_overflow | output | 1 | More than 20 visible entries were found |
| scan_done | output | 1 | Walk finished, by terminator or window close |
| scan_cut | output | 1 | Walk was ended by the window closing |

## Verification
The bench targets the following corner cases:
- **Display off during part of the window.** A linear chain of 80 entries is scanned with the display off for the first twenty scanning slots. A design that skipped too few slots, or that made up lost slots later, would list hits beyond entry 59.
- **Chain that loops back.** A design without the 80-entry limit would visit a visible entry twice and list it twice.
- **Height boundary.** An entry exactly 8×height lines above the line must be rejected, and one just below the line must not wrap to visible.
- **Corrupt link, overflow and early slots.** A link beyond the table, a chain of 30 visible entries, and strobes on slots 0 to 2 check the termination, list-limit and slot-gating rules.

Every cycle is compared against a behavioural queue model, so an off-by-one in the pairing of two entries per slot appears as an early or late count change.

// File: rtl/sts_pkg.sv
package sts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_END  = 2'd2,
        ST_CUT  = 2'd3
    } scan_state_t;
endpackage

// File: rtl/sts_entry_eval.sv
module sts_entry_eval #(
    parameter int YPOS_W   = 9,
    parameter int IDX_W    = 7,
    parameter int TBL_SIZE = 80,
    localparam int ENT_W   = YPOS_W + 2 + IDX_W
) (
    input  logic [ENT_W-1:0]  entry,
    input  logic [YPOS_W-1:0] line,
    output logic              hit,
    output logic [IDX_W-1:0]  link,
    output logic              link_ends
);
    logic [YPOS_W-1:0] ypos;
    logic [1:0]        cells_m1;
    logic [YPOS_W:0]   diff;
    logic [YPOS_W:0]   cells;
    logic [YPOS_W:0]   span;

    always_comb begin
        ypos      = entry[YPOS_W-1:0];
        cells_m1  = entry[YPOS_W+1:YPOS_W];
        link      = entry[ENT_W-1:YPOS_W+2];
        diff      = {1'b0, line} - {1'b0, ypos};
        cells     = (YPOS_W+1)'(cells_m1) + (YPOS_W+1)'(1);
        span      = cells << 3;
        hit       = !diff[YPOS_W] && (diff < span);
        link_ends = (link == '0) || (int'(link) >= TBL_SIZE);
    end
endmodule

// File: rtl/sts_vis_list.sv
module sts_vis_list #(
    parameter int IDX_W   = 7,
    parameter int MAX_VIS = 20,
    localparam int CNT_W  = $clog2(MAX_VIS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     push_a,
    input  logic [IDX_W-1:0]         idx_a,
    input  logic                     push_b,
    input  logic [IDX_W-1:0]         idx_b,
    output logic [MAX_VIS*IDX_W-1:0] list_flat,
    output logic [CNT_W-1:0]         count,
    output logic                     overflow
);
    logic [IDX_W-1:0] list_q [MAX_VIS];
    logic [IDX_W-1:0] list_n [MAX_VIS];
    logic [CNT_W-1:0] cnt_n;
    logic             ovf_n;

    always_comb begin
        list_n = list_q;
        cnt_n  = count;
        ovf_n  = overflow;
        if (push_a) begin
            if (cnt_n < CNT_W'(MAX_VIS)) begin
                list_n[cnt_n] = idx_a;
                cnt_n = cnt_n + CNT_W'(1);
            end else begin
                ovf_n = 1'b1;
            end
        end
        if (push_b) begin
            if (cnt_n < CNT_W'(MAX_VIS)) begin
                list_n[cnt_n] = idx_b;
                cnt_n = cnt_n + CNT_W'(1);
            end else begin
                ovf_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count    <= '0;
            overflow <= 1'b0;
            for (int k = 0; k < MAX_VIS; k++) list_q[k] <= '0;
        end else begin
            count    <= cnt_n;
            overflow <= ovf_n;
            list_q   <= list_n;
        end
    end

    for (genvar k = 0; k < MAX_VIS; k++) begin : g_flat
        assign list_flat[k*IDX_W +: IDX_W] = list_q[k];
    end
endmodule

// File: rtl/sprite_table_scanner.sv
module sprite_table_scanner #(
    parameter int TBL_SIZE   = 80,
    parameter int MAX_WALK   = 80,
    parameter int MAX_VIS    = 20,
    parameter int YPOS_W     = 9,
    parameter int SLOT_W     = 6,
    parameter int FIRST_SLOT = 3,
    parameter int CLOSE_SLOT = 53,
    localparam int IDX_W     = $clog2(TBL_SIZE),
    localparam int ENT_W     = YPOS_W + 2 + IDX_W,
    localparam int CNT_W     = $clog2(MAX_VIS + 1),
    localparam int VIS_W     = $clog2(MAX_WALK + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     line_start,
    input  logic [YPOS_W-1:0]        next_line,
    input  logic                     slot_strobe,
    input  logic [SLOT_W-1:0]        slot_idx,
    input  logic                     disp_en,
    output logic [IDX_W-1:0]         rd_addr_a,
    input  logic [ENT_W-1:0]         rd_data_a,
    output logic [IDX_W-1:0]         rd_addr_b,
    input  logic [ENT_W-1:0]         rd_data_b,
    output logic [MAX_VIS*IDX_W-1:0] vis_list,
    output logic [CNT_W-1:0]         vis_count,
    output logic                     vis_overflow,
    output logic                     scan_done,
    output logic                     scan_cut
);
    import sts_pkg::*;

    scan_state_t       state_q, state_n;
    logic [IDX_W-1:0]  cur_idx;
    logic [VIS_W-1:0]  visited;
    logic [YPOS_W-1:0] line_q;

    logic [ENT_W-1:0]  lane_ent  [2];
    logic              lane_hit  [2];
    logic [IDX_W-1:0]  lane_link [2];
    logic              lane_end  [2];

    logic in_window, do_scan, do_close, a_last, b_last, push_a, push_b;

    assign lane_ent[0] = rd_data_a;
    assign lane_ent[1] = rd_data_b;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        sts_entry_eval #(
            .YPOS_W  (YPOS_W),
            .IDX_W   (IDX_W),
            .TBL_SIZE(TBL_SIZE)
        ) u_eval (
            .entry    (lane_ent[g]),
            .line     (line_q),
            .hit      (lane_hit[g]),
            .link     (lane_link[g]),
            .link_ends(lane_end[g])
        );
    end

    // Slot qualification and per-lane termination.
    always_comb begin
        in_window = (int'(slot_idx) >= FIRST_SLOT) && (int'(slot_idx) < CLOSE_SLOT);
        do_scan   = (state_q == ST_WALK) && !line_start && slot_strobe
                    && disp_en && in_window;
        do_close  = (state_q == ST_WALK) && !line_start && slot_strobe
                    && (int'(slot_idx) >= CLOSE_SLOT);
        a_last    = lane_end[0] || (int'(visited) + 1 >= MAX_WALK);
        b_last    = lane_end[1] || (int'(visited) + 2 >= MAX_WALK);
    end

    // Next-state logic.
    always_comb begin
        state_n = state_q;
        if (line_start) begin
            state_n = ST_WALK;
        end else begin
            unique case (state_q)
                ST_IDLE: state_n = ST_IDLE;
                ST_WALK: begin
                    if (do_close)                      state_n = ST_CUT;
                    else if (do_scan && (a_last || b_last)) state_n = ST_END;
                end
                ST_END:  state_n = ST_END;
                ST_CUT:  state_n = ST_CUT;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // State register and walk position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_idx <= '0;
            visited <= '0;
            line_q  <= '0;
        end else begin
            state_q <= state_n;
            if (line_start) begin
                cur_idx <= '0;
                visited <= '0;
                line_q  <= next_line;
            end else if (do_scan) begin
                visited <= visited + (a_last ? VIS_W'(1) : VIS_W'(2));
                cur_idx <= lane_link[1];
            end
        end
    end

    // Outputs.
    always_comb begin
        rd_addr_a = cur_idx;
        rd_addr_b = a_last ? '0 : lane_link[0];
        push_a    = do_scan && lane_hit[0];
        push_b    = do_scan && !a_last && lane_hit[1];
        scan_done = (state_q == ST_END) || (state_q == ST_CUT);
        scan_cut  = (state_q == ST_CUT);
    end

    sts_vis_list #(
        .IDX_W  (IDX_W),
        .MAX_VIS(MAX_VIS)
    ) u_list (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (line_start),
        .push_a   (push_a),
        .idx_a    (cur_idx),
        .push_b   (push_b),
        .idx_b    (rd_addr_b),
        .list_flat(vis_list),
        .count    (vis_count),
        .overflow (vis_overflow)
    );
endmodule

// File: rtl/sts_checks.sv
module sts_checks #(
    parameter int MAX_VIS    = 20,
    parameter int SLOT_W     = 6,
    parameter int IDX_W      = 7,
    parameter int FIRST_SLOT = 3,
    parameter int CLOSE_SLOT = 53,
    localparam int CNT_W     = $clog2(MAX_VIS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic              slot_strobe,
    input logic [SLOT_W-1:0] slot_idx,
    input logic              disp_en,
    input logic [IDX_W-1:0]  rd_addr_a,
    input logic [CNT_W-1:0]  vis_count,
    input logic              vis_overflow,
    input logic              scan_done,
    input logic              scan_cut
);
    p_clear_on_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (vis_count == '0) && !vis_overflow && !scan_done && (rd_addr_a == '0));

    p_low_slot_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && slot_strobe && int'(slot_idx) < FIRST_SLOT)
        |=> $stable(vis_count) && $stable(rd_addr_a));

    p_two_per_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> int'(vis_count) <= int'($past(vis_count)) + 2);

    p_disp_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !disp_en) |=> $stable(vis_count) && $stable(rd_addr_a));

    p_cut_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_cut && !line_start) |=> scan_cut && scan_done && $stable(vis_count));

    p_cut_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_cut) |-> $past(slot_strobe) && int'($past(slot_idx)) >= CLOSE_SLOT);

    p_no_overflow_early_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vis_overflow |-> int'(vis_count) == MAX_VIS);
endmodule

bind sprite_table_scanner sts_checks #(
    .MAX_VIS   (MAX_VIS),
    .SLOT_W    (SLOT_W),
    .IDX_W     (IDX_W),
    .FIRST_SLOT(FIRST_SLOT),
    .CLOSE_SLOT(CLOSE_SLOT)
) u_sts_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .slot_strobe (slot_strobe),
    .slot_idx    (slot_idx),
    .disp_en     (disp_en),
    .rd_addr_a   (rd_addr_a),
    .vis_count   (vis_count),
    .vis_overflow(vis_overflow),
    .scan_done   (scan_done),
    .scan_cut    (scan_cut)
);

// File: tb/test_sprite_table_scanner.sv
module test_sprite_table_scanner;
    localparam int TBL = 80;
    localparam int MV  = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_start = 1'b0;
    logic [8:0]   next_line = '0;
    logic         slot_strobe = 1'b0;
    logic [5:0]   slot_idx = '0;
    logic         disp_en = 1'b1;
    logic [6:0]   rd_addr_a, rd_addr_b;
    logic [17:0]  rd_data_a, rd_data_b;
    logic [139:0] vis_list;
    logic [4:0]   vis_count;
    logic         vis_overflow, scan_done, scan_cut;

    logic [17:0] tbl [TBL];

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    assign rd_data_a = (int'(rd_addr_a) < TBL) ? tbl[rd_addr_a] : '0;
    assign rd_data_b = (int'(rd_addr_b) < TBL) ? tbl[rd_addr_b] : '0;

    sprite_table_scanner i_sprite_table_scanner (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .next_line(next_line),
        .slot_strobe(slot_strobe), .slot_idx(slot_idx), .disp_en(disp_en),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .vis_list(vis_list), .vis_count(vis_count), .vis_overflow(vis_overflow),
        .scan_done(scan_done), .scan_cut(scan_cut)
    );

    // Behavioural reference: 0 idle, 1 walking, 2 ended, 3 cut.
    int m_state = 0;
    int m_cur = 0;
    int m_vis = 0;
    int m_line = 0;
    bit m_ovf = 0;
    int m_q [$];

    function automatic logic [17:0] ent(int y, int cells, int lk);
        logic [17:0] e;
        e[8:0]   = 9'(y);
        e[10:9]  = 2'(cells - 1);
        e[17:11] = 7'(lk);
        return e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_q.delete(); m_ovf = 0; m_cur = 0; m_vis = 0;
        end else if (line_start) begin
            m_state = 1; m_q.delete(); m_ovf = 0; m_cur = 0; m_vis = 0;
            m_line = int'(next_line);
        end else if (m_state == 1 && slot_strobe && int'(slot_idx) >= 53) begin
            m_state = 3;
        end else if (m_state == 1 && slot_strobe && disp_en && slot_idx >= 3) begin
            for (int k = 0; k < 2 && m_state == 1; k++) begin
                int y, h, lk, d;
                y  = int'(tbl[m_cur][8:0]);
                h  = int'(tbl[m_cur][10:9]) + 1;
                lk = int'(tbl[m_cur][17:11]);
                d  = m_line - y;
                if (d >= 0 && d < 8 * h) begin
                    if (m_q.size() < MV) m_q.push_back(m_cur);
                    else m_ovf = 1;
                end
                m_vis++;
                if (lk == 0 || lk >= TBL || m_vis >= 80) m_state = 2;
                else m_cur = lk;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit ok;
            ok = (int'(vis_count) == m_q.size()) && (vis_overflow == m_ovf)
                 && (scan_done == (m_state >= 2)) && (scan_cut == (m_state == 3));
            for (int k = 0; k < m_q.size(); k++)
                if (int'(vis_list[k*7 +: 7]) != m_q[k]) ok = 0;
            n_cmp++;
            if (!ok) begin
                n_bad++;
                $display("FAIL model R3 R10 count=%0d/%0d ovf=%0b/%0b done=%0b/%0b cut=%0b/%0b (actual/expected)",
                         vis_count, m_q.size(), vis_overflow, m_ovf, scan_done, m_state >= 2,
                         scan_cut, m_state == 3);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_tbl();
        for (int i = 0; i < TBL; i++) tbl[i] = ent(300, 1, 0);
    endtask

    task automatic start_line(int ln);
        @(negedge clk);
        next_line = 9'(ln); line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic slot(int s, bit d);
        slot_strobe = 1'b1; slot_idx = 6'(s); disp_en = d;
        @(negedge clk);
        slot_strobe = 1'b0; disp_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_line(int ln, logic [63:0] mask);
        start_line(ln);
        for (int s = 0; s < 64; s++) slot(s, mask[s]);
    endtask

    function automatic int lst(int k);
        return int'(vis_list[k*7 +: 7]);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clr_tbl();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset count", int'(vis_count), 0);
        chk("R1 reset done", int'(scan_done), 0);

        // R9 / R6: height boundary and link-0 end
        clr_tbl();
        tbl[0] = ent(100, 1, 1);  // diff 0: visible
        tbl[1] = ent(93, 1, 2);   // diff 7: visible
        tbl[2] = ent(92, 1, 3);   // diff 8 with 1 cell: hidden
        tbl[3] = ent(69, 4, 4);   // diff 31 with 4 cells: visible
        tbl[4] = ent(101, 1, 0);  // negative diff: hidden, ends chain
        run_line(100, '1);
        chk("R9 count", int'(vis_count), 3);
        chk("R9 list0", lst(0), 0);
        chk("R9 list1", lst(1), 1);
        chk("R9 list2", lst(2), 3);
        chk("R6 done", int'(scan_done), 1);
        chk("R6 not cut", int'(scan_cut), 0);
        start_line(100);
        chk("R1 cleared count", int'(vis_count), 0);
        chk("R1 cleared done", int'(scan_done), 0);

        // R2 / R3: early slots ignored, then two per slot
        clr_tbl();
        for (int i = 0; i < 10; i++) tbl[i] = ent(100, 1, i + 1);
        for (int s = 0; s < 3; s++) slot(s, 1'b1);
        chk("R2 early slots count", int'(vis_count), 0);
        chk("R2 early slots addr", int'(rd_addr_a), 0);
        slot(3, 1'b1);
        chk("R3 first slot count", int'(vis_count), 2);
        chk("R3 first slot list1", lst(1), 1);
        slot(4, 1'b1);
        chk("R3 second slot count", int'(vis_count), 4);

        // R4 / R5: display off loses slots, window cuts the chain
        clr_tbl();
        for (int i = 0; i < TBL; i++) tbl[i] = ent((i >= 55 && i < 65) ? 100 : 300, 1, (i == 79) ? 0 : i + 1);
        begin
            logic [63:0] m;
            m = '1;
            for (int s = 3; s < 23; s++) m[s] = 1'b0;
            run_line(100, m);
        end
        chk("R4 count", int'(vis_count), 5);
        chk("R4 list0", lst(0), 55);
        chk("R4 list4", lst(4), 59);
        chk("R5 cut", int'(scan_cut), 1);
        run_line(100, '0);
        chk("R5 all off count", int'(vis_count), 0);
        chk("R5 all off cut", int'(scan_cut), 1);

        // R7: looping chain stops after 80 entries
        clr_tbl();
        for (int i = 0; i < TBL; i++) tbl[i] = ent((i == 1) ? 100 : 300, 1, (i == 79) ? 1 : i + 1);
        run_line(100, '1);
        chk("R7 count", int'(vis_count), 1);
        chk("R7 done", int'(scan_done), 1);
        chk("R7 not cut", int'(scan_cut), 0);

        // R10: overflow
        clr_tbl();
        for (int i = 0; i < 30; i++) tbl[i] = ent(100, 1, (i == 29) ? 0 : i + 1);
        run_line(100, '1);
        chk("R10 count", int'(vis_count), 20);
        chk("R10 overflow", int'(vis_overflow), 1);
        chk("R10 list19", lst(19), 19);

        // R8: corrupt link
        clr_tbl();
        tbl[0] = ent(100, 1, 1);
        tbl[1] = ent(100, 1, 100);
        run_line(100, '1);
        chk("R8 count", int'(vis_count), 2);
        chk("R8 done", int'(scan_done), 1);
        chk("R8 not cut", int'(scan_cut), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule